// File: doc/BRIEF.md
# UART hold-and-load debug controller

This block lets a host load and inspect a soft CPU's program memory over the same UART the CPU uses for its own console. The receive byte stream is fanned out unchanged to both the CPU and the controller. The transmit byte stream passes through a two-way selector that only the controller steers. After reset the CPU is held, so that it fetches nothing, and it owns the transmit line. The controller watches the receive stream for well-formed debug frames.

A frame is twelve bytes: sync 0xA5 then 0x5A, a command byte, a 32-bit address sent low byte first, a 32-bit data word sent low byte first, and a closing check byte. The check byte equals the XOR of the eleven bytes before it. The first accepted frame moves transmit ownership to the controller. While the CPU is held, the controller can write or read words through a single-cycle memory request port and send replies. A run command acknowledges, then releases the CPU and hands transmit back to it.

The serializers sit outside this block. Both UART sides are byte-wide valid/ready streams, and the receive side is valid only, because the line cannot be stalled.

Top module: `dbg_loader_top`

## Requirements
- R1: Out of reset, `cpu_hold` is 1, `tx_owner_dbg` is 0 (the CPU owns transmit) and `mem_req` is 0.
- R2: `cpu_rx_valid`/`cpu_rx_data` always equal `rx_valid`/`rx_data` in the same cycle, whatever the controller is doing.
- R3: While `tx_owner_dbg` is 0, `tx_valid` and `tx_data` follow `cpu_tx_valid` and `cpu_tx_data`, and `cpu_tx_ready` follows `tx_ready`. While it is 1, `cpu_tx_ready` is 0.
- R4: Bytes that do not form a frame cause no memory access, no reply byte and no change of ownership or hold.
- R5: Command 0x01 (write word), sent while the CPU is held, issues exactly one `mem_req` with `mem_we`=1 at the frame's address and data. It then sends one byte 0x06, and `tx_owner_dbg` becomes 1.
- R6: Command 0x02 (read word), sent while the CPU is held, issues one read request. The word returned on `mem_rdata` one cycle after the request is sent as four bytes, least significant first, and the byte order holds when `tx_ready` stalls.
- R7: Command 0x03 (run) sends 0x06. Once that byte is taken, `cpu_hold` goes to 0 and `tx_owner_dbg` goes to 0 in the same cycle. The hold never returns until reset.
- R8: A run command received while the CPU is already running is still answered with 0x06. `cpu_hold` stays 0 and ownership ends back at the CPU.
- R9: If 0x0F00 (`TIMEOUT_CYC`) clock cycles pass with no byte while a frame is part way through, the partial frame is dropped and the parser waits for sync again. A mid-frame gap shorter than that is tolerated.
- R10: A 0xA5 received where 0x5A is expected is taken as a new first sync byte, so 0xA5 0xA5 0x5A starts a frame.
- R11: Write and read commands received while the CPU runs are discarded, with no memory request, no reply and no ownership change.
- R12: A frame whose last byte differs from the XOR of its first eleven bytes is discarded.
- R13: A checksum-correct frame whose command is not 0x01, 0x02 or 0x03 is discarded.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low reset |
| rx_valid | input | 1 | Received byte strobe from the UART receiver |
| rx_data | input | 8 | Received byte |
| cpu_rx_valid | output | 1 | Received byte strobe to the CPU |
| cpu_rx_data | output | 8 | Received byte to the CPU |
| cpu_tx_valid | input | 1 | CPU transmit byte valid |
| cpu_tx_data | input | 8 | CPU transmit byte |
| cpu_tx_ready | output | 1 | Transmit ready back to the CPU |
| tx_valid | output | 1 | Transmit byte valid to the UART transmitter |
| tx_data | output | 8 | Transmit byte |
| tx_ready | input | 1 | UART transmitter ready |
| tx_owner_dbg | output | 1 | 1 when the controller owns transmit |
| cpu_hold | output | 1 | 1 keeps the CPU from fetching |
| mem_req | output | 1 | One-cycle memory request |
| mem_we | output | 1 | Write enable for the request |
| mem_addr | output | 32 | Memory word address |
| mem_wdata | output | 32 | Memory write data |
| mem_rdata | input | 32 | Read data, valid the cycle after a read request |

## Verification
The parser is driven with several kinds of traffic. Stray bytes, a frame with a corrupt check byte and a frame with an unknown command must all leave ownership and memory untouched, which separates sync matching from checksum and command gating. A doubled first sync byte and two mid-frame gaps, one just above the timeout and one just below, show whether resynchronisation and the idle limit sit on the right cycle. Writes followed by reads under a stalling transmitter test the memory sequencing and the byte order, and run commands, given once held and once already running, together with writes sent after release, separate the hold state from the transmit ownership.

// File: rtl/dbg_pkg.sv
package dbg_pkg;
  localparam int WORD_W     = 32;
  localparam int WORD_BYTES = WORD_W / 8;
  localparam int FRAME_LEN  = 2 + 1 + 2 * WORD_BYTES + 1;
  localparam int IDX_W      = $clog2(FRAME_LEN);

  localparam logic [7:0] SYNC_A  = 8'hA5;
  localparam logic [7:0] SYNC_B  = 8'h5A;
  localparam logic [7:0] ACK_BYTE = 8'h06;

  typedef enum logic [7:0] {
    OP_WRITE = 8'h01,
    OP_READ  = 8'h02,
    OP_RUN   = 8'h03
  } op_e;

  function automatic logic op_known(input logic [7:0] op);
    return (op == OP_WRITE) || (op == OP_READ) || (op == OP_RUN);
  endfunction

  // Running check byte: fold one more byte into the XOR.
  function automatic logic [7:0] fold_check(input logic [7:0] acc, input logic [7:0] b);
    return acc ^ b;
  endfunction

  // Little-endian word assembly: new byte enters at the top, older bytes move down.
  function automatic logic [WORD_W-1:0] shift_in_le(input logic [WORD_W-1:0] w, input logic [7:0] b);
    return {b, w[WORD_W-1:8]};
  endfunction
endpackage

// File: rtl/dbg_frame_rx.sv
module dbg_frame_rx
  import dbg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 32'h0F00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              frame_ok,
  output logic [7:0]        frame_op,
  output logic [WORD_W-1:0] frame_addr,
  output logic [WORD_W-1:0] frame_data,
  output logic              timeout_hit
);
  localparam int CNT_W = $clog2(TIMEOUT_CYC + 1);
  localparam logic [IDX_W-1:0] IDX_OP   = IDX_W'(2);
  localparam logic [IDX_W-1:0] IDX_ADDR = IDX_W'(3);
  localparam logic [IDX_W-1:0] IDX_DATA = IDX_W'(3 + WORD_BYTES);
  localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(FRAME_LEN - 1);

  logic [IDX_W-1:0] idx;
  logic [7:0]       chk;
  logic [CNT_W-1:0] gap;
  logic             byte_is_last;

  assign timeout_hit  = (idx != '0) && !rx_valid && (gap == CNT_W'(TIMEOUT_CYC - 1));
  assign byte_is_last = rx_valid && (idx == IDX_LAST);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      idx        <= '0;
      chk        <= '0;
      gap        <= '0;
      frame_ok   <= 1'b0;
      frame_op   <= '0;
      frame_addr <= '0;
      frame_data <= '0;
    end else begin
      frame_ok <= 1'b0;
      if (timeout_hit) begin
        idx <= '0;
        gap <= '0;
      end else if (rx_valid) begin
        gap <= '0;
        if (idx == '0) begin
          if (rx_data == SYNC_A) begin
            idx <= IDX_W'(1);
            chk <= rx_data;
          end
        end else if (idx == IDX_W'(1)) begin
          if (rx_data == SYNC_B) begin
            idx <= IDX_OP;
            chk <= fold_check(chk, rx_data);
          end else if (rx_data == SYNC_A) begin
            idx <= IDX_W'(1);
            chk <= rx_data;
          end else begin
            idx <= '0;
          end
        end else if (byte_is_last) begin
          idx      <= '0;
          frame_ok <= (rx_data == chk) && op_known(frame_op);
        end else begin
          chk <= fold_check(chk, rx_data);
          idx <= idx + IDX_W'(1);
          if (idx == IDX_OP) frame_op <= rx_data;
          else if (idx < IDX_DATA) frame_addr <= shift_in_le(frame_addr, rx_data);
          else frame_data <= shift_in_le(frame_data, rx_data);
        end
      end else if (idx != '0) begin
        gap <= gap + CNT_W'(1);
      end
    end
  end

  // A frame takes many bytes, so acceptances never come back to back (R12).
  assert_frame_pulse_R12: assert property (@(posedge clk) disable iff (!rst_n)
    frame_ok |=> !frame_ok);

  // An aborted frame never yields an acceptance on the next cycle (R9).
  assert_timeout_drops_R9: assert property (@(posedge clk) disable iff (!rst_n)
    timeout_hit |=> !frame_ok);

  logic unused_addr_idx;
  assign unused_addr_idx = (IDX_ADDR == '0);
endmodule

// File: rtl/dbg_cmd_seq.sv
module dbg_cmd_seq
  import dbg_pkg::*;
(
  input  logic              clk,
  input  logic              rst_n,
  input  logic              frame_ok,
  input  logic [7:0]        frame_op,
  input  logic [WORD_W-1:0] frame_addr,
  input  logic [WORD_W-1:0] frame_data,
  output logic              cpu_hold,
  output logic              owner_dbg,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata,
  output logic              dbg_tx_valid,
  output logic [7:0]        dbg_tx_data,
  input  logic              dbg_tx_ready
);
  localparam int CNT_W = $clog2(WORD_BYTES + 1);

  typedef enum logic [2:0] { ST_IDLE, ST_WR, ST_RD, ST_CAP, ST_SEND } st_e;

  st_e               st;
  logic [WORD_W-1:0] sbuf;
  logic [CNT_W-1:0]  left;
  logic              run_pending;
  logic              send_done;
  logic              accept;

  assign mem_req      = (st == ST_WR) || (st == ST_RD);
  assign mem_we       = (st == ST_WR);
  assign dbg_tx_valid = (st == ST_SEND);
  assign dbg_tx_data  = sbuf[7:0];
  assign send_done    = (st == ST_SEND) && dbg_tx_ready && (left == CNT_W'(1));
  assign accept       = (st == ST_IDLE) && frame_ok &&
                        ((frame_op == OP_RUN) || cpu_hold);

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st          <= ST_IDLE;
      sbuf        <= '0;
      left        <= '0;
      run_pending <= 1'b0;
      cpu_hold    <= 1'b1;
      owner_dbg   <= 1'b0;
      mem_addr    <= '0;
      mem_wdata   <= '0;
    end else begin
      case (st)
        ST_IDLE: if (accept) begin
          owner_dbg <= 1'b1;
          mem_addr  <= frame_addr;
          mem_wdata <= frame_data;
          if (frame_op == OP_RUN) begin
            sbuf        <= WORD_W'(ACK_BYTE);
            left        <= CNT_W'(1);
            run_pending <= 1'b1;
            st          <= ST_SEND;
          end else if (frame_op == OP_WRITE) begin
            st <= ST_WR;
          end else begin
            st <= ST_RD;
          end
        end
        ST_WR: begin
          sbuf <= WORD_W'(ACK_BYTE);
          left <= CNT_W'(1);
          st   <= ST_SEND;
        end
        ST_RD:  st <= ST_CAP;
        ST_CAP: begin
          sbuf <= mem_rdata;
          left <= CNT_W'(WORD_BYTES);
          st   <= ST_SEND;
        end
        ST_SEND: if (dbg_tx_ready) begin
          sbuf <= sbuf >> 8;
          left <= left - CNT_W'(1);
          if (send_done) begin
            st <= ST_IDLE;
            if (run_pending) begin
              run_pending <= 1'b0;
              cpu_hold    <= 1'b0;
              owner_dbg   <= 1'b0;
            end
          end
        end
        default: st <= ST_IDLE;
      endcase
    end
  end

  // Memory is touched only while the CPU is held (R11).
  assert_mem_only_held_R11: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |-> cpu_hold);

  // Each command issues a single one-cycle request (R5).
  assert_single_req_R5: assert property (@(posedge clk) disable iff (!rst_n)
    mem_req |=> !mem_req);

  // Once released, the CPU stays released (R7).
  assert_hold_sticky_R7: assert property (@(posedge clk) disable iff (!rst_n)
    !cpu_hold |=> !cpu_hold);

  // Release and hand-back of transmit land together (R7).
  assert_release_handback_R7: assert property (@(posedge clk) disable iff (!rst_n)
    $fell(cpu_hold) |-> !owner_dbg);

  // Replies go out only while the controller owns transmit (R3).
  assert_reply_owned_R3: assert property (@(posedge clk) disable iff (!rst_n)
    dbg_tx_valid |-> owner_dbg);
endmodule

// File: rtl/dbg_tx_mux.sv
module dbg_tx_mux (
  input  logic       sel_dbg,
  input  logic       cpu_valid,
  input  logic [7:0] cpu_data,
  output logic       cpu_ready,
  input  logic       dbg_valid,
  input  logic [7:0] dbg_data,
  output logic       dbg_ready,
  output logic       line_valid,
  output logic [7:0] line_data,
  input  logic       line_ready
);
  always_comb begin
    if (sel_dbg) begin
      line_valid = dbg_valid;
      line_data  = dbg_data;
      cpu_ready  = 1'b0;
      dbg_ready  = line_ready;
    end else begin
      line_valid = cpu_valid;
      line_data  = cpu_data;
      cpu_ready  = line_ready;
      dbg_ready  = 1'b0;
    end
  end
endmodule

// File: rtl/dbg_loader_top.sv
module dbg_loader_top
  import dbg_pkg::*;
#(
  parameter int TIMEOUT_CYC = 32'h0F00
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              rx_valid,
  input  logic [7:0]        rx_data,
  output logic              cpu_rx_valid,
  output logic [7:0]        cpu_rx_data,
  input  logic              cpu_tx_valid,
  input  logic [7:0]        cpu_tx_data,
  output logic              cpu_tx_ready,
  output logic              tx_valid,
  output logic [7:0]        tx_data,
  input  logic              tx_ready,
  output logic              tx_owner_dbg,
  output logic              cpu_hold,
  output logic              mem_req,
  output logic              mem_we,
  output logic [WORD_W-1:0] mem_addr,
  output logic [WORD_W-1:0] mem_wdata,
  input  logic [WORD_W-1:0] mem_rdata
);
  logic              frame_ok;
  logic [7:0]        frame_op;
  logic [WORD_W-1:0] frame_addr;
  logic [WORD_W-1:0] frame_data;
  logic              timeout_hit;
  logic              dbg_tx_valid;
  logic [7:0]        dbg_tx_data;
  logic              dbg_tx_ready;
  logic              unused_timeout;

  assign cpu_rx_valid   = rx_valid;
  assign cpu_rx_data    = rx_data;
  assign unused_timeout = timeout_hit;

  dbg_frame_rx #(.TIMEOUT_CYC(TIMEOUT_CYC)) u_rx (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .frame_ok(frame_ok), .frame_op(frame_op), .frame_addr(frame_addr),
    .frame_data(frame_data), .timeout_hit(timeout_hit)
  );

  dbg_cmd_seq u_seq (
    .clk(clk), .rst_n(rst_n), .frame_ok(frame_ok), .frame_op(frame_op),
    .frame_addr(frame_addr), .frame_data(frame_data), .cpu_hold(cpu_hold),
    .owner_dbg(tx_owner_dbg), .mem_req(mem_req), .mem_we(mem_we),
    .mem_addr(mem_addr), .mem_wdata(mem_wdata), .mem_rdata(mem_rdata),
    .dbg_tx_valid(dbg_tx_valid), .dbg_tx_data(dbg_tx_data),
    .dbg_tx_ready(dbg_tx_ready)
  );

  dbg_tx_mux u_mux (
    .sel_dbg(tx_owner_dbg), .cpu_valid(cpu_tx_valid), .cpu_data(cpu_tx_data),
    .cpu_ready(cpu_tx_ready), .dbg_valid(dbg_tx_valid), .dbg_data(dbg_tx_data),
    .dbg_ready(dbg_tx_ready), .line_valid(tx_valid), .line_data(tx_data),
    .line_ready(tx_ready)
  );

  // The receive stream reaches the CPU untouched (R2).
  assert_rx_fanout_R2: assert property (@(posedge clk) disable iff (!rst_n)
    cpu_rx_valid == rx_valid);
endmodule

// File: tb/sim_dbg_loader_top.sv
`timescale 1ns/1ps
module sim_dbg_loader_top;
  localparam int TO = 32'h0F00;
  localparam logic [7:0] CPU_BYTE = 8'h43;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic rx_valid = 1'b0;
  logic [7:0] rx_data = 8'h00;
  logic cpu_rx_valid;
  logic [7:0] cpu_rx_data;
  logic cpu_tx_valid = 1'b1;
  logic [7:0] cpu_tx_data = CPU_BYTE;
  logic cpu_tx_ready;
  logic tx_valid;
  logic [7:0] tx_data;
  logic tx_ready = 1'b1;
  logic tx_owner_dbg;
  logic cpu_hold;
  logic mem_req;
  logic mem_we;
  logic [31:0] mem_addr;
  logic [31:0] mem_wdata;
  logic [31:0] mem_rdata = 32'h0;

  always #4 clk = ~clk;

  dbg_loader_top #(.TIMEOUT_CYC(TO)) u0 (
    .clk(clk), .rst_n(rst_n), .rx_valid(rx_valid), .rx_data(rx_data),
    .cpu_rx_valid(cpu_rx_valid), .cpu_rx_data(cpu_rx_data),
    .cpu_tx_valid(cpu_tx_valid), .cpu_tx_data(cpu_tx_data),
    .cpu_tx_ready(cpu_tx_ready), .tx_valid(tx_valid), .tx_data(tx_data),
    .tx_ready(tx_ready), .tx_owner_dbg(tx_owner_dbg), .cpu_hold(cpu_hold),
    .mem_req(mem_req), .mem_we(mem_we), .mem_addr(mem_addr),
    .mem_wdata(mem_wdata), .mem_rdata(mem_rdata)
  );

  int tests = 0;
  int fails = 0;
  bit done = 0;

  // Reference state: what hold and ownership must be when traffic is quiet.
  bit settled = 0;
  bit exp_hold = 1;
  bit exp_owner = 0;
  bit stall_mode = 0;
  int reqs_seen = 0;

  logic [31:0] mem_model [int unsigned];
  logic [63:0] wr_q[$];
  logic [7:0]  reply_q[$];

  task automatic chk(input bit ok, input string tag, input longint act, input longint exp);
    tests++;
    if (!ok) begin
      fails++;
      $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
    end
  endtask

  // Memory model: writes land at the edge, reads return the next cycle.
  always @(posedge clk) begin
    if (rst_n && mem_req) begin
      reqs_seen++;
      if (mem_we) begin
        mem_model[mem_addr] = mem_wdata;
        wr_q.push_back({mem_addr, mem_wdata});
      end else begin
        mem_rdata <= mem_model.exists(mem_addr) ? mem_model[mem_addr] : 32'h0;
      end
    end
    if (rst_n && tx_valid && tx_ready && tx_owner_dbg) reply_q.push_back(tx_data);
  end

  // Transmitter stall pattern and every-cycle reference comparison.
  always @(negedge clk) begin
    tx_ready <= stall_mode ? ~tx_ready : 1'b1;
    if (rst_n) begin
      chk(cpu_rx_valid == rx_valid && cpu_rx_data == rx_data, "R2 rx fanout",
          {cpu_rx_valid, cpu_rx_data}, {rx_valid, rx_data});
      if (settled) begin
        chk(cpu_hold == exp_hold && tx_owner_dbg == exp_owner, "R3 hold/owner track",
            {cpu_hold, tx_owner_dbg}, {exp_hold, exp_owner});
        if (!exp_owner)
          chk(tx_valid == cpu_tx_valid && tx_data == cpu_tx_data && cpu_tx_ready == tx_ready,
              "R3 cpu path", {tx_valid, tx_data, cpu_tx_ready}, {cpu_tx_valid, cpu_tx_data, tx_ready});
        else
          chk(cpu_tx_ready == 1'b0, "R3 cpu blocked", cpu_tx_ready, 0);
      end
    end
  end

  task automatic put_byte(input logic [7:0] b, input int gap);
    @(negedge clk);
    rx_valid = 1'b1;
    rx_data  = b;
    @(negedge clk);
    rx_valid = 1'b0;
    repeat (gap) @(negedge clk);
  endtask

  // Builds the twelve frame bytes; the last is the XOR of the rest.
  task automatic make_frame(input logic [7:0] op, input logic [31:0] a, input logic [31:0] d,
                            input bit corrupt, output logic [7:0] f [12]);
    logic [7:0] x;
    f[0] = 8'hA5; f[1] = 8'h5A; f[2] = op;
    for (int i = 0; i < 4; i++) begin
      f[3 + i] = a[8*i +: 8];
      f[7 + i] = d[8*i +: 8];
    end
    x = 8'h00;
    for (int i = 0; i < 11; i++) x = x ^ f[i];
    f[11] = corrupt ? ~x : x;
  endtask

  task automatic send_frame(input logic [7:0] op, input logic [31:0] a, input logic [31:0] d,
                            input bit corrupt);
    logic [7:0] f [12];
    make_frame(op, a, d, corrupt, f);
    for (int i = 0; i < 12; i++) put_byte(f[i], 1);
  endtask

  task automatic quiesce(input bit h, input bit o);
    repeat (40) @(negedge clk);
    exp_hold = h;
    exp_owner = o;
    repeat (3) @(negedge clk);
    settled = 1;
    repeat (5) @(negedge clk);
  endtask

  task automatic expect_none(input string tag, input int reqs_before);
    chk(reply_q.size() == 0, {tag, " no reply"}, reply_q.size(), 0);
    chk(reqs_seen == reqs_before, {tag, " no mem access"}, reqs_seen, reqs_before);
  endtask

  task automatic expect_ack(input string tag);
    chk(reply_q.size() == 1 && reply_q[0] == 8'h06, {tag, " ack"},
        reply_q.size() > 0 ? reply_q[0] : 8'hFF, 8'h06);
    reply_q.delete();
  endtask

  task automatic expect_write(input string tag, input logic [31:0] a, input logic [31:0] d);
    chk(wr_q.size() == 1 && wr_q[0] == {a, d}, {tag, " write"},
        wr_q.size() > 0 ? wr_q[0] : 64'h0, {a, d});
    wr_q.delete();
  endtask

  task automatic expect_word(input string tag, input logic [31:0] w);
    logic [31:0] got;
    got = 32'h0;
    for (int i = 0; i < reply_q.size() && i < 4; i++) got[8*i +: 8] = reply_q[i];
    chk(reply_q.size() == 4 && got == w, {tag, " read bytes"}, got, w);
    reply_q.delete();
  endtask

  initial begin : watchdog
    repeat (150000) @(posedge clk);
    if (!done) begin
      fails++;
      tests++;
      $display("FAIL watchdog actual=hung expected=finished");
      $display("  [TB] %0d tests run, %0d failed", tests, fails);
      $finish;
    end
  end

  initial begin : main
    int r0;
    repeat (3) @(negedge clk);
    chk(cpu_hold == 1'b1 && tx_owner_dbg == 1'b0 && mem_req == 1'b0, "R1 reset state",
        {cpu_hold, tx_owner_dbg, mem_req}, 3'b100);
    rst_n = 1'b1;
    @(negedge clk);
    chk(cpu_hold == 1'b1 && tx_owner_dbg == 1'b0 && mem_req == 1'b0, "R1 after reset",
        {cpu_hold, tx_owner_dbg, mem_req}, 3'b100);
    settled = 1;
    repeat (10) @(negedge clk);

    // R4: stray bytes, including a lone first sync byte.
    r0 = reqs_seen;
    put_byte(8'h11, 0); put_byte(8'h5A, 2); put_byte(8'hA5, 0); put_byte(8'h33, 3);
    quiesce(1, 0);
    expect_none("R4", r0);

    // R12: corrupt check byte.
    settled = 0; r0 = reqs_seen;
    send_frame(8'h01, 32'h100, 32'hCAFE0000, 1);
    quiesce(1, 0);
    expect_none("R12", r0);

    // R13: unknown command with a good check byte.
    settled = 0; r0 = reqs_seen;
    send_frame(8'h07, 32'h100, 32'h0, 0);
    quiesce(1, 0);
    expect_none("R13", r0);

    // R5: write while held.
    settled = 0;
    send_frame(8'h01, 32'h100, 32'hDEADBEEF, 0);
    quiesce(1, 1);
    expect_write("R5", 32'h100, 32'hDEADBEEF);
    expect_ack("R5");

    // R10: doubled first sync byte.
    settled = 0;
    put_byte(8'hA5, 1);
    send_frame(8'h01, 32'h104, 32'h01234567, 0);
    quiesce(1, 1);
    expect_write("R10", 32'h104, 32'h01234567);
    expect_ack("R10");

    // R6: reads with a stalling transmitter.
    settled = 0; stall_mode = 1;
    send_frame(8'h02, 32'h100, 32'h0, 0);
    quiesce(1, 1);
    expect_word("R6 addr 100", 32'hDEADBEEF);
    settled = 0;
    send_frame(8'h02, 32'h104, 32'h0, 0);
    quiesce(1, 1);
    expect_word("R6 addr 104", 32'h01234567);
    stall_mode = 0;

    // R9: gap over the limit drops the frame.
    begin
      logic [7:0] f [12];
      settled = 0; r0 = reqs_seen;
      make_frame(8'h01, 32'h200, 32'h11223344, 0, f);
      for (int i = 0; i < 6; i++) put_byte(f[i], 1);
      repeat (TO + 5) @(negedge clk);
      for (int i = 6; i < 12; i++) put_byte(f[i], 1);
      quiesce(1, 1);
      expect_none("R9 long gap", r0);
      settled = 0;
      make_frame(8'h01, 32'h204, 32'h55667788, 0, f);
      for (int i = 0; i < 6; i++) put_byte(f[i], 1);
      repeat (TO - 10) @(negedge clk);
      for (int i = 6; i < 12; i++) put_byte(f[i], 1);
      quiesce(1, 1);
      expect_write("R9 short gap", 32'h204, 32'h55667788);
      expect_ack("R9 short gap");
    end

    // R7: run releases the CPU and hands back transmit.
    settled = 0;
    send_frame(8'h03, 32'h0, 32'h0, 0);
    quiesce(0, 0);
    expect_ack("R7");
    chk(cpu_hold == 1'b0 && tx_owner_dbg == 1'b0, "R7 released",
        {cpu_hold, tx_owner_dbg}, 2'b00);

    // R11: write and read while running are discarded.
    settled = 0; r0 = reqs_seen;
    send_frame(8'h01, 32'h300, 32'hFFFF0000, 0);
    send_frame(8'h02, 32'h100, 32'h0, 0);
    quiesce(0, 0);
    expect_none("R11", r0);
    chk(wr_q.size() == 0, "R11 no write", wr_q.size(), 0);

    // R8: run again while running.
    settled = 0;
    send_frame(8'h03, 32'h0, 32'h0, 0);
    quiesce(0, 0);
    expect_ack("R8");
    chk(cpu_hold == 1'b0 && tx_owner_dbg == 1'b0, "R8 unchanged",
        {cpu_hold, tx_owner_dbg}, 2'b00);

    done = 1;
    $display("  [TB] %0d tests run, %0d failed", tests, fails);
    $finish;
  end
endmodule